// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the byte-wide arithmetic and logic datapath of an accumulator-based processor core. The core presents the accumulator byte, a second operand byte, the current status byte and an operation code, and raises `op_valid` for one cycle. On the next clock edge the block registers a result byte and a new status byte. The core then writes these back to the accumulator and the flag register.

Each operation class follows its own flag rule. Arithmetic refreshes all five flags. The logic operations force carry to zero. Rotates touch only carry. Increment and decrement leave carry alone. Complement-accumulator leaves every flag as it was. Any flag that an operation does not update is copied from `flags_in`.

One code reports only the carry out of a 16-bit register-pair addition. The sum itself is formed elsewhere.

Top module: `acc_alu_core`

## Requirements
- R1: The status byte places sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bit 1 of `flags_q` always reads 1, and bits 5 and 3 always read 0. After reset, `res_q` is 0x00, `flags_q` is 0x02 and `res_valid` is 0.
- R2: When `op_valid` is high at a rising edge, `res_q` and `flags_q` take the new values at that edge, and `res_valid` is high for the following cycle. When `op_valid` is low, `res_q` and `flags_q` hold their values and `res_valid` is low.
- R3: Add (code 0) computes A+B. Add-with-carry (code 1) computes A+B+CY. Carry is the carry out of bit 7 and auxiliary carry is the carry out of bit 3. Sign, zero and parity are taken from the result.
- R4: Subtract (code 2) and subtract-with-borrow (code 3) form A + ~B + k, where k is 1 for subtract and the inverse of the incoming carry for subtract-with-borrow. Carry is set to the inverse of the bit-7 carry out, which is the borrow. Auxiliary carry is the carry out of bit 3 of that same sum.
- R5: Compare (code 7) sets all five flags exactly as subtract would, and returns A unchanged on `res_q`.
- R6: AND (code 4) clears carry, sets auxiliary carry to the OR of bit 3 of A and bit 3 of B, and takes sign, zero and parity from A&B.
- R7: XOR (code 5) and OR (code 6) clear both carry and auxiliary carry, and take sign, zero and parity from the result.
- R8: Sign copies result bit 7. Zero is set when the result is 0x00. Parity is set when the result has an even number of 1 bits.
- R9: Four rotates are provided: left circular (code 8), right circular (code 9), left through carry (code 10) and right through carry (code 11). The circular rotates copy the bit shifted out into carry. The through-carry rotates move the old carry into the vacated bit and the bit shifted out into carry. No other flag changes.
- R10: Complement accumulator (code 12) returns ~A and changes no flag. Complement carry (code 13) inverts carry only. Set carry (code 14) forces carry to 1. Codes 13 and 14 return A.
- R11: Increment (code 15) computes A+1 and decrement (code 16) computes A-1. Both update sign, zero and parity. Auxiliary carry is set when A's low nibble is 0xF (increment) or non-zero (decrement). Carry is kept.
- R12: Decimal adjust (code 17) works in two steps. It first adds 0x06 when A's low nibble exceeds 9 or auxiliary carry is set; auxiliary carry becomes that step's bit-3 carry out. It then adds 0x60 when the intermediate high nibble exceeds 9, when carry is set, or when the first step carried out of bit 7. A carry out of either step sets carry, and carry is never cleared. Sign, zero and parity are taken from the final byte.
- R13: Pair-add carry (code 18) sets carry to the carry out of bit 15 of `pair_x`+`pair_y`, keeps all other flags, and returns A.
- R14: Codes 19 to 31 return A and copy `flags_in` unchanged, apart from the fixed bits of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator byte (A) |
| opnd_in | input | 8 | Second operand byte (B) |
| flags_in | input | 8 | Current status byte |
| pair_x | input | 16 | First register-pair value for code 18 |
| pair_y | input | 16 | Second register-pair value for code 18 |
| res_q | output | 8 | Registered result byte |
| flags_q | output | 8 | Registered status byte |
| res_valid | output | 1 | Result registered in the previous edge |

## Verification
Decimal adjust can apply both of its corrections in one cycle. The low-nibble fix then feeds a carry into the high-nibble test within the same combinational path. This is provoked with A = 0x9B: the low step gives 0xA1 with auxiliary carry, and the high step wraps the result to 0x01 with carry set, so the expected status byte is 0x13. It is also provoked with A = 0xFF, where the first step itself carries out of bit 7; the expected result is 0x65. Each case is judged against a bench model written from R12, at the cycle after the strobe.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 5;

  localparam int FB_SIGN = 7;
  localparam int FB_ZERO = 6;
  localparam int FB_HALF = 4;
  localparam int FB_PAR  = 2;
  localparam int FB_CY   = 0;

  localparam logic [DATA_W-1:0] FLAG_KEEP_MASK = 8'hD5;
  localparam logic [DATA_W-1:0] FLAG_ONE_BITS  = 8'h02;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBB  = 5'd3,
    OP_AND  = 5'd4,  OP_XOR  = 5'd5,  OP_OR   = 5'd6,  OP_CMP  = 5'd7,
    OP_RLC  = 5'd8,  OP_RRC  = 5'd9,  OP_RAL  = 5'd10, OP_RAR  = 5'd11,
    OP_CMA  = 5'd12, OP_CMC  = 5'd13, OP_STC  = 5'd14, OP_INC  = 5'd15,
    OP_DEC  = 5'd16, OP_DAA  = 5'd17, OP_PAIR = 5'd18
  } alu_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] sum;
    logic              half;
    logic              full;
  } add_out_t;

  function automatic add_out_t f_add(input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b,
                                     input logic              cin);
    add_out_t o;
    logic [DATA_W:0] wide;
    logic [NIB_W:0]  low;
    wide   = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    low    = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    o.sum  = wide[DATA_W-1:0];
    o.full = wide[DATA_W];
    o.half = low[NIB_W];
    return o;
  endfunction

  function automatic logic f_even_par(input logic [DATA_W-1:0] v);
    return ~(^v);
  endfunction

  function automatic logic [DATA_W-1:0] f_norm(input logic [DATA_W-1:0] f);
    return (f & FLAG_KEEP_MASK) | FLAG_ONE_BITS;
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import acc_alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cy_in,
  output logic [DATA_W-1:0] res,
  output logic              half,
  output logic              cy
);
  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic              is_sub;
  add_out_t          ao;

  always_comb begin
    b_eff  = b;
    c_eff  = 1'b0;
    is_sub = 1'b0;
    unique case (op)
      OP_ADC: c_eff = cy_in;
      OP_SUB, OP_CMP: begin b_eff = ~b; c_eff = 1'b1; is_sub = 1'b1; end
      OP_SBB: begin b_eff = ~b; c_eff = ~cy_in; is_sub = 1'b1; end
      OP_INC: b_eff = {{(DATA_W-1){1'b0}}, 1'b1};
      OP_DEC: b_eff = {DATA_W{1'b1}};
      default: ;
    endcase
  end

  assign ao   = f_add(a, b_eff, c_eff);
  assign res  = ao.sum;
  assign half = ao.half;
  assign cy   = is_sub ? ~ao.full : ao.full;
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cy_in,
  output logic [DATA_W-1:0] res,
  output logic              half,
  output logic              cy
);
  always_comb begin
    res  = a;
    half = 1'b0;
    cy   = cy_in;
    unique case (op)
      OP_AND: begin res = a & b; half = a[NIB_W-1] | b[NIB_W-1]; cy = 1'b0; end
      OP_XOR: begin res = a ^ b; cy = 1'b0; end
      OP_OR:  begin res = a | b; cy = 1'b0; end
      OP_RLC: begin res = {a[DATA_W-2:0], a[DATA_W-1]}; cy = a[DATA_W-1]; end
      OP_RRC: begin res = {a[0], a[DATA_W-1:1]};        cy = a[0]; end
      OP_RAL: begin res = {a[DATA_W-2:0], cy_in};       cy = a[DATA_W-1]; end
      OP_RAR: begin res = {cy_in, a[DATA_W-1:1]};       cy = a[0]; end
      OP_CMA: res = ~a;
      OP_CMC: cy = ~cy_in;
      OP_STC: cy = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj
  import acc_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic              half_in,
  input  logic              cy_in,
  output logic [DATA_W-1:0] res,
  output logic              half,
  output logic              cy,
  output logic              lo_fix,
  output logic              hi_fix
);
  localparam logic [DATA_W-1:0] LO_ADJ = 8'h06;
  localparam logic [DATA_W-1:0] HI_ADJ = 8'h60;
  localparam logic [NIB_W-1:0]  NIB_MAX = 4'd9;

  add_out_t s1, s2;

  assign lo_fix = (a[NIB_W-1:0] > NIB_MAX) | half_in;
  assign s1     = f_add(a, lo_fix ? LO_ADJ : '0, 1'b0);
  assign hi_fix = (s1.sum[DATA_W-1:NIB_W] > NIB_MAX) | cy_in | s1.full;
  assign s2     = f_add(s1.sum, hi_fix ? HI_ADJ : '0, 1'b0);
  assign res    = s2.sum;
  assign half   = s1.half;
  assign cy     = cy_in | s1.full | s2.full;
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int PAIR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic [DATA_W-1:0] flags_in,
  input  logic [PAIR_W-1:0] pair_x,
  input  logic [PAIR_W-1:0] pair_y,
  output logic [DATA_W-1:0] res_q,
  output logic [DATA_W-1:0] flags_q,
  output logic              res_valid
);
  alu_op_e           op;
  logic [DATA_W-1:0] fl_in_n;
  logic [DATA_W-1:0] ar_res, lg_res, da_res;
  logic              ar_half, ar_cy, lg_half, lg_cy, da_half, da_cy;
  logic              da_lo_fix, da_hi_fix;
  logic [PAIR_W:0]   pair_sum;
  logic              pair_cy;

  // Named internal events, observed by the checker
  logic [DATA_W-1:0] w_res_next;
  logic [DATA_W-1:0] w_flag_next;
  logic [DATA_W-1:0] w_szp_src;
  logic              w_upd_szp, w_upd_half, w_upd_cy;
  logic              w_half_val, w_cy_val;

  assign op      = alu_op_e'(op_sel);
  assign fl_in_n = f_norm(flags_in);

  alu_addsub u_addsub (
    .op(op), .a(acc_in), .b(opnd_in), .cy_in(flags_in[FB_CY]),
    .res(ar_res), .half(ar_half), .cy(ar_cy)
  );

  alu_logic u_logic (
    .op(op), .a(acc_in), .b(opnd_in), .cy_in(flags_in[FB_CY]),
    .res(lg_res), .half(lg_half), .cy(lg_cy)
  );

  alu_decadj u_decadj (
    .a(acc_in), .half_in(flags_in[FB_HALF]), .cy_in(flags_in[FB_CY]),
    .res(da_res), .half(da_half), .cy(da_cy),
    .lo_fix(da_lo_fix), .hi_fix(da_hi_fix)
  );

  assign pair_sum = {1'b0, pair_x} + {1'b0, pair_y};
  assign pair_cy  = pair_sum[PAIR_W];

  always_comb begin
    w_res_next = acc_in;
    w_szp_src  = acc_in;
    w_upd_szp  = 1'b0;
    w_upd_half = 1'b0;
    w_upd_cy   = 1'b0;
    w_half_val = fl_in_n[FB_HALF];
    w_cy_val   = fl_in_n[FB_CY];
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        w_res_next = ar_res; w_szp_src = ar_res;
        w_upd_szp = 1'b1; w_upd_half = 1'b1; w_upd_cy = 1'b1;
        w_half_val = ar_half; w_cy_val = ar_cy;
      end
      OP_CMP: begin
        w_szp_src = ar_res;
        w_upd_szp = 1'b1; w_upd_half = 1'b1; w_upd_cy = 1'b1;
        w_half_val = ar_half; w_cy_val = ar_cy;
      end
      OP_INC, OP_DEC: begin
        w_res_next = ar_res; w_szp_src = ar_res;
        w_upd_szp = 1'b1; w_upd_half = 1'b1; w_half_val = ar_half;
      end
      OP_AND, OP_XOR, OP_OR: begin
        w_res_next = lg_res; w_szp_src = lg_res;
        w_upd_szp = 1'b1; w_upd_half = 1'b1; w_upd_cy = 1'b1;
        w_half_val = lg_half; w_cy_val = lg_cy;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        w_res_next = lg_res; w_upd_cy = 1'b1; w_cy_val = lg_cy;
      end
      OP_CMA: w_res_next = lg_res;
      OP_CMC, OP_STC: begin w_upd_cy = 1'b1; w_cy_val = lg_cy; end
      OP_DAA: begin
        w_res_next = da_res; w_szp_src = da_res;
        w_upd_szp = 1'b1; w_upd_half = 1'b1; w_upd_cy = 1'b1;
        w_half_val = da_half; w_cy_val = da_cy;
      end
      OP_PAIR: begin w_upd_cy = 1'b1; w_cy_val = pair_cy; end
      default: ;
    endcase
  end

  always_comb begin
    w_flag_next = fl_in_n;
    if (w_upd_szp) begin
      w_flag_next[FB_SIGN] = w_szp_src[DATA_W-1];
      w_flag_next[FB_ZERO] = (w_szp_src == '0);
      w_flag_next[FB_PAR]  = f_even_par(w_szp_src);
    end
    if (w_upd_half) w_flag_next[FB_HALF] = w_half_val;
    if (w_upd_cy)   w_flag_next[FB_CY]   = w_cy_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q     <= '0;
      flags_q   <= FLAG_ONE_BITS;
      res_valid <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_q   <= w_res_next;
        flags_q <= w_flag_next;
      end
    end
  end
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
  import acc_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [OP_W-1:0]   op_sel,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] flags_in,
  input logic [DATA_W-1:0] res_q,
  input logic [DATA_W-1:0] flags_q,
  input logic              res_valid,
  input logic              w_upd_szp
);
  logic szp_on_res;
  assign szp_on_res = w_upd_szp && (op_sel != OP_CMP);

  assert_fixed_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[1] && !flags_q[3] && !flags_q[5]);

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(res_q) && $stable(flags_q)));

  assert_cmp_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_CMP) |=> res_q == $past(acc_in));

  assert_logic_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == OP_OR || op_sel == OP_XOR)) |=> (!flags_q[FB_CY] && !flags_q[FB_HALF]));

  assert_zero_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && szp_on_res) |=> (flags_q[FB_ZERO] == (res_q == '0)) && (flags_q[FB_SIGN] == res_q[7]));

  assert_incdec_keep_cy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == OP_INC || op_sel == OP_DEC)) |=> flags_q[FB_CY] == $past(flags_in[FB_CY]));

  assert_cma_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_CMA) |=> flags_q == (($past(flags_in) & FLAG_KEEP_MASK) | FLAG_ONE_BITS));
endmodule

bind acc_alu_core acc_alu_checker i_acc_alu_checker (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
  .acc_in(acc_in), .flags_in(flags_in), .res_q(res_q), .flags_q(flags_q),
  .res_valid(res_valid), .w_upd_szp(w_upd_szp)
);

// File: tb/test_acc_alu_core.sv
module test_acc_alu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_sel = '0;
  logic [7:0]  acc_in = '0, opnd_in = '0, flags_in = 8'h02;
  logic [15:0] pair_x = '0, pair_y = '0;
  logic [7:0]  res_q, flags_q;
  logic        res_valid;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  acc_alu_core i_acc_alu_core (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
    .pair_x(pair_x), .pair_y(pair_y),
    .res_q(res_q), .flags_q(flags_q), .res_valid(res_valid)
  );

  function automatic int par_even(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  // Independent model written from the requirements
  task automatic model(input int op, a, b, f, px, py, output int r, output int fl);
    int s, z, h, p, c, val, bb, cin, sum, lo, t1, t2;
    bit szp;
    s = (f >> 7) & 1; z = (f >> 6) & 1; h = (f >> 4) & 1; p = (f >> 2) & 1; c = f & 1;
    cin = c; r = a; val = a; szp = 0;
    case (op)
      0, 1, 2, 3, 7: begin
        bb  = (op >= 2) ? (255 - b) : b;
        lo  = (op == 1) ? cin : (op == 2 || op == 7) ? 1 : (op == 3) ? 1 - cin : 0;
        sum = a + bb + lo;
        h   = (((a & 15) + (bb & 15) + lo) > 15) ? 1 : 0;
        c   = (sum > 255) ? 1 : 0;
        if (op >= 2) c = 1 - c;
        val = sum & 255; szp = 1;
        r   = (op == 7) ? a : val;
      end
      4: begin val = a & b; c = 0; h = ((a | b) >> 3) & 1; szp = 1; r = val; end
      5: begin val = a ^ b; c = 0; h = 0; szp = 1; r = val; end
      6: begin val = a | b; c = 0; h = 0; szp = 1; r = val; end
      8: begin c = (a >> 7) & 1; r = ((a << 1) & 255) | c; end
      9: begin c = a & 1; r = (a >> 1) | (c << 7); end
      10: begin c = (a >> 7) & 1; r = ((a << 1) & 255) | cin; end
      11: begin c = a & 1; r = (a >> 1) | (cin << 7); end
      12: r = 255 - a;
      13: c = 1 - cin;
      14: c = 1;
      15: begin val = (a + 1) & 255; h = ((a & 15) == 15) ? 1 : 0; szp = 1; r = val; end
      16: begin val = (a + 255) & 255; h = ((a & 15) != 0) ? 1 : 0; szp = 1; r = val; end
      17: begin
        t1 = a;
        if ((a & 15) > 9 || h == 1) begin h = ((a & 15) + 6 > 15) ? 1 : 0; t1 = a + 6; end
        else h = 0;
        if (t1 > 255) c = 1;
        t1 = t1 & 255;
        t2 = t1;
        if ((t1 >> 4) > 9 || c == 1) t2 = t1 + 96;
        if (t2 > 255) c = 1;
        val = t2 & 255; szp = 1; r = val;
      end
      18: c = (px + py > 65535) ? 1 : 0;
      default: ;
    endcase
    if (szp) begin
      s = (val >> 7) & 1; z = (val == 0) ? 1 : 0; p = par_even(val);
    end
    fl = (s << 7) | (z << 6) | (h << 4) | (p << 2) | 2 | c;
  endtask

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  // Drive at the falling edge, capture at the rising edge, sample at the next falling edge
  task automatic run_op(input int op, a, b, f, input int px = 0, input int py = 0);
    @(negedge clk);
    op_sel = op[4:0]; acc_in = a[7:0]; opnd_in = b[7:0]; flags_in = f[7:0];
    pair_x = px[15:0]; pair_y = py[15:0]; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic op_and_check(input string req, input int op, a, b, f, input int px = 0, input int py = 0);
    int er, ef;
    run_op(op, a, b, f, px, py);
    model(op, a, b, f, px, py, er, ef);
    check(req, res_q, er);
    check(req, flags_q, ef);
    check({req, " valid"}, res_valid, 1);
  endtask

  task automatic t_reset;
    check("R1 reset res", res_q, 8'h00);
    check("R1 reset flags", flags_q, 8'h02);
    check("R1 reset valid", res_valid, 0);
  endtask

  task automatic t_add;
    run_op(0, 8'h7F, 8'h01, 8'h02);
    check("R3 add 7F+01 res", res_q, 8'h80);
    check("R3 add 7F+01 flags", flags_q, 8'h92);
    op_and_check("R3 add carry out", 0, 8'hF0, 8'h20, 8'h02);
    op_and_check("R3 adc with cy", 1, 8'h0F, 8'h00, 8'h03);
    op_and_check("R3 adc wrap to zero", 1, 8'hFF, 8'h00, 8'h01);
  endtask

  task automatic t_sub;
    run_op(2, 8'h00, 8'h01, 8'h03);
    check("R4 sub 00-01 res", res_q, 8'hFF);
    check("R4 sub 00-01 flags", flags_q, 8'h87);
    op_and_check("R4 sbb with borrow", 3, 8'h10, 8'h0F, 8'h03);
    op_and_check("R4 sbb no borrow", 3, 8'h10, 8'h10, 8'h02);
  endtask

  task automatic t_cmp;
    run_op(7, 8'h05, 8'h05, 8'h02);
    check("R5 cmp equal res", res_q, 8'h05);
    check("R5 cmp equal flags", flags_q, 8'h56);
    op_and_check("R5 cmp less", 7, 8'h03, 8'h80, 8'hFF);
  endtask

  task automatic t_logic;
    op_and_check("R6 and half from bit3", 4, 8'h08, 8'h01, 8'h13);
    op_and_check("R6 and zero", 4, 8'hF0, 8'h0F, 8'h03);
    op_and_check("R7 xor clears", 5, 8'hAA, 8'h55, 8'h13);
    op_and_check("R7 or clears", 6, 8'h00, 8'h00, 8'h13);
    op_and_check("R8 parity odd", 6, 8'h07, 8'h00, 8'h02);
  endtask

  task automatic t_rot;
    run_op(11, 8'h01, 8'h00, 8'h02);
    check("R9 rar res", res_q, 8'h00);
    check("R9 rar flags", flags_q, 8'h03);
    op_and_check("R9 rlc", 8, 8'h81, 8'h00, 8'hC6);
    op_and_check("R9 rrc", 9, 8'h02, 8'h00, 8'h03);
    op_and_check("R9 ral", 10, 8'h40, 8'h00, 8'h03);
  endtask

  task automatic t_carryops;
    op_and_check("R10 cma", 12, 8'h5A, 8'h00, 8'hD7);
    op_and_check("R10 cmc", 13, 8'h12, 8'h00, 8'h55);
    op_and_check("R10 stc", 14, 8'h12, 8'h00, 8'h02);
  endtask

  task automatic t_incdec;
    run_op(16, 8'h00, 8'h00, 8'h03);
    check("R11 dcr 00 res", res_q, 8'hFF);
    check("R11 dcr 00 flags", flags_q, 8'h87);
    run_op(15, 8'hFF, 8'h00, 8'h02);
    check("R11 inr FF res", res_q, 8'h00);
    check("R11 inr FF flags", flags_q, 8'h56);
    op_and_check("R11 dcr 10", 16, 8'h10, 8'h00, 8'h02);
  endtask

  task automatic t_daa;
    run_op(17, 8'h9B, 8'h00, 8'h02);
    check("R12 daa both steps res", res_q, 8'h01);
    check("R12 daa both steps flags", flags_q, 8'h13);
    run_op(17, 8'hFF, 8'h00, 8'h02);
    check("R12 daa step1 carry res", res_q, 8'h65);
    op_and_check("R12 daa via half", 17, 8'h12, 8'h00, 8'h12);
    op_and_check("R12 daa keeps cy", 17, 8'h23, 8'h00, 8'h03);
    op_and_check("R12 daa none", 17, 8'h45, 8'h00, 8'h02);
  endtask

  task automatic t_pair;
    run_op(18, 8'h33, 8'h00, 8'h02, 16'h8000, 16'h8000);
    check("R13 pair carry res", res_q, 8'h33);
    check("R13 pair carry flags", flags_q, 8'h03);
    op_and_check("R13 pair no carry", 18, 8'h33, 8'h00, 8'hD5, 16'h7FFF, 16'h8000);
  endtask

  task automatic t_unused;
    op_and_check("R14 code 19", 19, 8'hA5, 8'h11, 8'hFF);
    op_and_check("R14 code 31", 31, 8'h3C, 8'h11, 8'h00);
  endtask

  task automatic t_hold;
    int r0, f0;
    run_op(0, 8'h12, 8'h34, 8'h02);
    r0 = res_q; f0 = flags_q;
    @(negedge clk);
    op_sel = 5'd12; acc_in = 8'h00; flags_in = 8'hFF;
    repeat (2) @(negedge clk);
    check("R2 idle holds res", res_q, r0);
    check("R2 idle holds flags", flags_q, f0);
    check("R2 idle valid low", res_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_rot();
    t_carryops();
    t_incdec();
    t_daa();
    t_pair();
    t_unused();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule